// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block brings an asynchronous DRAM out of power-on and then keeps its rows alive with CAS-before-RAS refresh cycles. When reset is released it holds all strobes inactive for a programmable power-up pause. It then runs a fixed number of CAS-before-RAS initialization cycles and raises `init_done`. From that point an interval timer produces refresh ticks. With the default parameters and a 100 MHz clock, the interval is 1500 cycles, which sits below the 15.6 µs average needed for 2048 rows in 32 ms. Each tick is added to a small pending counter.

An access port shares the DRAM through a request/grant handshake. While the sequencer is idle and no refresh is pending, a request is granted. A granted port that reports a cycle in flight (`acc_busy`) keeps the bus, and refreshes are deferred and counted. As soon as the port is between cycles and work is pending, the grant is dropped and the refreshes run back to back. A tick that arrives when the counter is already full sets a sticky error flag.

The strobe outputs are those of the sequencer alone. They are inactive (high) whenever the access port holds the grant, so an outer multiplexer can merge them with the access side. Refresh needs no address because the DRAM supplies the row itself. Write enable is never driven low.

Top module: `dram_ref_seq`

States: `ST_PAUSE` (power-up wait), `ST_CBR_CAS` (CAS low, RAS high), `ST_CBR_RAS` (both low), `ST_PRECHG` (both high), `ST_IDLE` (bus free or granted). Transitions:
- pause expired: `ST_PAUSE`→`ST_CBR_CAS`
- setup done: `ST_CBR_CAS`→`ST_CBR_RAS`
- RAS width done: `ST_CBR_RAS`→`ST_PRECHG`
- precharge done, more init cycles owed: `ST_PRECHG`→`ST_CBR_CAS`
- precharge done, init complete or normal refresh: `ST_PRECHG`→`ST_IDLE`
- pending refresh and port not mid-cycle: `ST_IDLE`→`ST_CBR_CAS`

## Requirements
- R1: While reset is asserted: `ras_n`=1, `cas_n`=all ones, `we_n`=1, and `init_done`, `acc_gnt`, `ref_req`, `ref_err` are all 0.
- R2: After reset is released, the strobes stay high for PAUSE_CYC clock edges. The first CAS fall follows edge number PAUSE_CYC, counting the first edge after release as 1.
- R3: Exactly INIT_CYCLES RAS pulses occur before `init_done` rises. It rises on edge PAUSE_CYC + INIT_CYCLES×(T_CSR+T_RAS+T_RP) and stays high.
- R4: All CAS lines fall together (0 or all ones only). CAS is low for T_CSR cycles before RAS falls, stays low for the whole RAS-low time, and rises with RAS.
- R5: RAS is low for exactly T_RAS cycles. After RAS rises, both strobes are high for at least T_RP cycles before CAS falls again.
- R6: `we_n` is 1 in every cycle.
- R7: After init, with the bus not held, refresh RAS falls occur at edges T0+k×REF_INTERVAL+1+T_CSR for k≥1, where T0 is the edge of R3.
- R8: `acc_gnt` rises one cycle after the sequencer becomes idle with `acc_req` high and nothing pending. It is never high before `init_done`, nor while any strobe is low.
- R9: While granted with `acc_busy` high, the grant is kept, no refresh is issued, and `ref_req` is 1 once a tick is pending.
- R10: Up to QDEPTH refreshes are held. When `acc_busy` falls they run back to back, with the first RAS fall T_CSR+1 edges after the release edge and later ones T_CSR+T_RAS+T_RP+1 cycles apart.
- R11: `ref_err` stays 0 while QDEPTH refreshes are pending. It is set by a tick that arrives with QDEPTH pending and holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access port asks for the bus |
| acc_busy | input | 1 | Granted access port is inside a memory cycle |
| acc_gnt | output | 1 | Bus granted to the access port |
| ref_req | output | 1 | At least one refresh pending |
| ref_err | output | 1 | Sticky pending-counter overflow |
| init_done | output | 1 | Power-up and initialization complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_W | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
Every strobe edge is registered. A CAS fall appears one edge after the state change that requests it, a RAS fall T_CSR edges later, and `init_done` and `acc_gnt` one edge after the deciding condition. A pending refresh with a free bus reaches RAS T_CSR+1 edges after its tick. The bench keeps an edge counter that starts at reset release, and its driver computes each expected RAS-fall edge from these latencies. A monitor compares the fall edges it observes at the falling clock edge against that queue, while the strobe widths, grant exclusion and `init_done` edge are checked on the exact cycle the rules above predict.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE   = 3'd0,
        ST_CBR_CAS = 3'd1,
        ST_CBR_RAS = 3'd2,
        ST_PRECHG  = 3'd3,
        ST_IDLE    = 3'd4
    } seq_state_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int INTERVAL = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= TW'(INTERVAL - 1);
        end else if (en) begin
            if (cnt_q == '0) cnt_q <= TW'(INTERVAL - 1);
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = en && (cnt_q == '0);
endmodule

// File: rtl/ref_pend_queue.sv
module ref_pend_queue #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic nonzero,
    output logic overflow
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            unique case ({push, pop})
                2'b10: begin
                    if (cnt_q == CW'(DEPTH)) ovf_q <= 1'b1;
                    else                     cnt_q <= cnt_q + 1'b1;
                end
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign nonzero  = (cnt_q != '0);
    assign overflow = ovf_q;
endmodule

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
    parameter int PW      = 16,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic          done
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= PW'(RST_VAL);
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
    import dram_ref_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int T_CSR        = 2,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 5,
    parameter int INIT_CYCLES  = 8,
    parameter int REF_INTERVAL = 1500,
    parameter int QDEPTH       = 8,
    parameter int CAS_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic             acc_busy,
    output logic             acc_gnt,
    output logic             ref_req,
    output logic             ref_err,
    output logic             init_done,
    output logic             ras_n,
    output logic [CAS_W-1:0] cas_n,
    output logic             we_n
);
    localparam int MAXLEN = max_of4(PAUSE_CYC, T_CSR, T_RAS, T_RP);
    localparam int PW     = $clog2(MAXLEN + 1);
    localparam int IW     = $clog2(INIT_CYCLES + 1);

    seq_state_t    st_q, st_d;
    logic          gnt_q, gnt_d;
    logic          done_q, done_d;
    logic [IW-1:0] icnt_q, icnt_d;
    logic          phase_done, phase_load;
    logic [PW-1:0] phase_val;
    logic          tick, pend_nz, pop;

    // Length of each timed state, loaded on entry
    seq_phase_timer #(.PW(PW), .RST_VAL(PAUSE_CYC - 1)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .done     (phase_done)
    );

    ref_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (done_q),
        .tick  (tick)
    );

    ref_pend_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tick),
        .pop      (pop),
        .nonzero  (pend_nz),
        .overflow (ref_err)
    );

    // Next-state and transition logic
    always_comb begin
        st_d   = st_q;
        gnt_d  = gnt_q;
        done_d = done_q;
        icnt_d = icnt_q;
        pop    = 1'b0;
        unique case (st_q)
            ST_PAUSE: begin
                if (phase_done) st_d = ST_CBR_CAS;
            end
            ST_CBR_CAS: begin
                if (phase_done) st_d = ST_CBR_RAS;
            end
            ST_CBR_RAS: begin
                if (phase_done) st_d = ST_PRECHG;
            end
            ST_PRECHG: begin
                if (phase_done) begin
                    if (done_q) begin
                        st_d = ST_IDLE;
                    end else if (icnt_q == IW'(INIT_CYCLES - 1)) begin
                        done_d = 1'b1;
                        icnt_d = '0;
                        st_d   = ST_IDLE;
                    end else begin
                        icnt_d = icnt_q + 1'b1;
                        st_d   = ST_CBR_CAS;
                    end
                end
            end
            ST_IDLE: begin
                if (gnt_q && acc_busy) begin
                    gnt_d = 1'b1;
                end else if (pend_nz) begin
                    gnt_d = 1'b0;
                    pop   = 1'b1;
                    st_d  = ST_CBR_CAS;
                end else begin
                    gnt_d = acc_req;
                end
            end
            default: st_d = ST_PAUSE;
        endcase
    end

    always_comb begin
        phase_load = (st_d != st_q);
        unique case (st_d)
            ST_CBR_CAS: phase_val = PW'(T_CSR - 1);
            ST_CBR_RAS: phase_val = PW'(T_RAS - 1);
            ST_PRECHG:  phase_val = PW'(T_RP - 1);
            default:    phase_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_PAUSE;
            gnt_q  <= 1'b0;
            done_q <= 1'b0;
            icnt_q <= '0;
        end else begin
            st_q   <= st_d;
            gnt_q  <= gnt_d;
            done_q <= done_d;
            icnt_q <= icnt_d;
        end
    end

    // Outputs from the current state
    always_comb begin
        ras_n     = (st_q != ST_CBR_RAS);
        cas_n     = ((st_q == ST_CBR_CAS) || (st_q == ST_CBR_RAS)) ? '0 : '1;
        we_n      = 1'b1;
        acc_gnt   = gnt_q;
        init_done = done_q;
        ref_req   = pend_nz;
    end
endmodule

// File: rtl/dram_ref_seq_chk.sv
module dram_ref_seq_chk #(
    parameter int T_RAS = 6,
    parameter int CAS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_busy,
    input logic             acc_gnt,
    input logic             ref_req,
    input logic             ref_err,
    input logic             init_done,
    input logic             ras_n,
    input logic [CAS_W-1:0] cas_n
);
    logic [15:0] ras_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      ras_low_cnt <= '0;
        else if (!ras_n) ras_low_cnt <= ras_low_cnt + 1'b1;
        else             ras_low_cnt <= '0;
    end

    a_r8_gnt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (ras_n && (cas_n == '1)));

    a_r8_no_gnt_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !acc_gnt);

    a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == '0));

    a_r4_cas_low_during_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (cas_n == '0));

    a_r4_cas_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n == '0) || (cas_n == '1));

    a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_low_cnt == 16'(T_RAS)));

    a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r9_gnt_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_gnt && acc_busy) |=> acc_gnt);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ref_err |=> ref_err);

    a_r11_err_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_err) |-> ref_req);
endmodule

bind dram_ref_seq dram_ref_seq_chk #(.T_RAS(T_RAS), .CAS_W(CAS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_busy  (acc_busy),
    .acc_gnt   (acc_gnt),
    .ref_req   (ref_req),
    .ref_err   (ref_err),
    .init_done (init_done),
    .ras_n     (ras_n),
    .cas_n     (cas_n)
);

// File: tb/test_dram_ref_seq.sv
module test_dram_ref_seq;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 50;
    localparam int CSR = 2;
    localparam int RAS = 4;
    localparam int RP  = 3;
    localparam int NI  = 8;
    localparam int IV  = 60;
    localparam int QD  = 8;
    localparam int CW  = 4;
    localparam int C   = CSR + RAS + RP;
    localparam int T0  = P + NI * C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0;
    logic          acc_busy = 1'b0;
    logic          acc_gnt, ref_req, ref_err, init_done, ras_n, we_n;
    logic [CW-1:0] cas_n;

    dram_ref_seq #(
        .PAUSE_CYC(P), .T_CSR(CSR), .T_RAS(RAS), .T_RP(RP),
        .INIT_CYCLES(NI), .REF_INTERVAL(IV), .QDEPTH(QD), .CAS_W(CW)
    ) i_dram_ref_seq (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_busy(acc_busy),
        .acc_gnt(acc_gnt), .ref_req(ref_req), .ref_err(ref_err),
        .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Scoreboard of expected RAS-fall edges
    int    exp_q[$];
    string sb_tag = "R3";
    bit    sb_on  = 0;
    int    fall_cnt = 0;

    // Monitor
    logic          prev_ras = 1'b1;
    logic [CW-1:0] prev_cas = '1;
    int cas_low_run = 0;
    int ras_low_run = 0;
    int high_run    = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(we_n == 1'b1, "R6 we_n", int'(we_n), 1);
            chk((cas_n == '0) || (cas_n == '1), "R4 cas_uniform", int'(cas_n), 0);
            chk(!(acc_gnt && (!ras_n || cas_n != '1)), "R8 gnt_exclusive", int'(acc_gnt), 0);
            chk(!(acc_gnt && !init_done), "R8 gnt_before_init", int'(acc_gnt), 0);
            cas_low_run = (cas_n == '0) ? cas_low_run + 1 : 0;
            if (prev_ras && !ras_n) begin
                fall_cnt++;
                chk(cas_low_run == CSR + 1, "R4 cas_setup", cas_low_run - 1, CSR);
                if (sb_on) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, sb_tag, cyc, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(cyc == e, sb_tag, cyc, e);
                    end
                end
            end
            if (!prev_ras && ras_n) begin
                chk(ras_low_run == RAS, "R5 ras_width", ras_low_run, RAS);
                chk(cas_n == '1, "R4 cas_rises_with_ras", int'(cas_n), 15);
            end
            if (prev_cas == '1 && cas_n == '0 && fall_cnt > 0)
                chk(high_run >= RP, "R5 precharge", high_run, RP);
            ras_low_run = !ras_n ? ras_low_run + 1 : 0;
            high_run    = (ras_n && cas_n == '1) ? high_run + 1 : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at edge %0d", cyc);
        finish_run();
    end

    // Driver
    initial begin
        int f3, bb, g, n0;
        acc_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(ras_n == 1'b1 && cas_n == '1 && we_n == 1'b1, "R1 strobes", int'(ras_n), 1);
        chk(!init_done && !acc_gnt, "R1 flags", int'(init_done) + int'(acc_gnt), 0);
        chk(!ref_req && !ref_err, "R1 queue", int'(ref_req) + int'(ref_err), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NI; i++) exp_q.push_back(P + CSR + i * C);
        for (int k = 1; k <= 3; k++) exp_q.push_back(T0 + k * IV + 1 + CSR);
        sb_tag = "R3 R7 fall_edge";
        sb_on  = 1;

        wait_cyc(P - 1);
        chk(cas_n == '1 && ras_n, "R2 pause_quiet", int'(cas_n), 15);
        wait_cyc(P);
        chk(cas_n == '0, "R2 first_cas", int'(cas_n), 0);

        wait_cyc(T0 - 1);
        chk(init_done == 1'b0, "R3 init_not_yet", int'(init_done), 0);
        chk(fall_cnt == NI, "R3 init_count", fall_cnt, NI);
        wait_cyc(T0);
        chk(init_done == 1'b1, "R3 init_done", int'(init_done), 1);
        chk(acc_gnt == 1'b0, "R8 gnt_latency", int'(acc_gnt), 0);
        wait_cyc(T0 + 1);
        chk(acc_gnt == 1'b1, "R8 gnt_after_idle", int'(acc_gnt), 1);

        wait_cyc(T0 + IV + 1 + CSR + RAS + RP);
        chk(acc_gnt == 1'b0, "R8 gnt_not_yet", int'(acc_gnt), 0);
        wait_cyc(T0 + IV + 1 + CSR + RAS + RP + 1);
        chk(acc_gnt == 1'b1, "R8 regrant", int'(acc_gnt), 1);

        f3 = T0 + 3 * IV + 1 + CSR;
        wait_cyc(f3 + 1);
        chk(exp_q.size() == 0, "R7 all_periodic_seen", exp_q.size(), 0);
        sb_on = 0;

        // Bus held across three ticks
        wait_cyc(f3 + C);
        chk(acc_gnt == 1'b1, "R9 granted", int'(acc_gnt), 1);
        acc_busy = 1'b1;
        n0 = fall_cnt;
        wait_cyc(f3 + C + 3 * IV);
        chk(fall_cnt == n0, "R9 no_refresh", fall_cnt, n0);
        chk(ref_req == 1'b1, "R9 ref_req", int'(ref_req), 1);
        chk(acc_gnt == 1'b1, "R9 gnt_kept", int'(acc_gnt), 1);
        bb = f3 + C + 3 * IV + 1;
        for (int k = 0; k < 3; k++) exp_q.push_back(bb + CSR + k * (C + 1));
        sb_tag = "R10 drain_edge";
        sb_on  = 1;
        acc_busy = 1'b0;
        wait_cyc(bb + CSR + 2 * (C + 1) + 1);
        chk(exp_q.size() == 0, "R10 drain_count", exp_q.size(), 0);
        chk(ref_req == 1'b0, "R10 queue_empty", int'(ref_req), 0);
        sb_on = 0;

        // Overflow of the pending counter
        g = bb + CSR + 2 * (C + 1) + C;
        wait_cyc(g);
        chk(acc_gnt == 1'b1, "R11 granted", int'(acc_gnt), 1);
        acc_busy = 1'b1;
        n0 = fall_cnt;
        wait_cyc(g + QD * IV);
        chk(ref_err == 1'b0, "R11 full_no_err", int'(ref_err), 0);
        chk(fall_cnt == n0, "R9 still_deferred", fall_cnt, n0);
        wait_cyc(g + (QD + 1) * IV);
        chk(ref_err == 1'b1, "R11 overflow", int'(ref_err), 1);
        acc_busy = 1'b0;
        acc_req  = 1'b0;
        wait_cyc(g + (QD + 1) * IV + 12 * (C + 1));
        chk(ref_err == 1'b1, "R11 sticky", int'(ref_err), 1);
        chk(acc_gnt == 1'b0, "R8 no_req_no_gnt", int'(acc_gnt), 0);
        chk(fall_cnt > n0, "R10 resumed", fall_cnt, n0 + 1);
        finish_run();
    end
endmodule